// File: doc/BRIEF.md
# Polled and Interrupt-Driven Terminal Register Block

This block gives a processor a character terminal through four word registers on a simple load/store bus. One side receives characters from an input port, as a keyboard would. The other side sends characters to an output port, as a display would. Each side has a control word and a data word. The control word holds a ready flag that only the device can change, and an interrupt-enable flag that software sets.

Software can poll the ready flag, or it can enable the interrupt for that side. Loading the receive data word consumes the character. Storing to the transmit data word starts a send that takes a fixed number of cycles. The interrupt line of each side is high whenever that side is both enabled and ready. If the side is already ready, the line therefore rises in the cycle after the enable bit is written.

Top module: `mmio_term`

## Requirements
- R1: The registers sit at word offsets from parameter `BASE` (default 0xFFFF0000): receive control +0, receive data +4, transmit control +8, transmit data +12. Address bits 1:0 are ignored. An access whose bits above bit 3 differ from `BASE` reads zero and changes nothing.
- R2: In a control word, bit 0 is the ready flag and bit 1 is the interrupt enable. The enable is taken from bit 1 of a store. All other control bits read as zero.
- R3: A store to a control word never changes that side's ready flag.
- R4: When `rx_in_valid` is high at a clock edge, receive ready becomes 1 and `rx_in_char` is held. A load of receive data returns the held character in bits 7:0, with zeros above.
- R5: A load of receive data clears receive ready at that edge. If a character arrives at the same edge, ready stays 1 and the new character is held.
- R6: A character that arrives while receive ready is already 1 replaces the held character.
- R7: A store to transmit data while transmit ready is 1 clears ready and latches bits 7:0. Exactly `TX_DELAY` edges later, `tx_out_valid` pulses for one cycle with that character, and ready returns to 1 at the same edge.
- R8: A store to transmit data while transmit ready is 0 is ignored. It does not change the character being sent or the timing.
- R9: `rx_irq` and `tx_irq` are each high exactly while that side's enable and ready are both 1. A line rises in the cycle after its enable is stored if that side is ready.
- R10: After reset, both enables are 0, receive ready is 0, transmit ready is 1, and `tx_out_valid` is 0.
- R11: A store to receive data has no effect. A load of transmit data returns zero and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Store data |
| bus_rdata | output | DATA_W | Load data, valid in the cycle of the load |
| rx_in_valid | input | 1 | Input character present |
| rx_in_char | input | CHAR_W | Input character |
| tx_out_valid | output | 1 | One-cycle pulse when a character is sent |
| tx_out_char | output | CHAR_W | Sent character |
| rx_irq | output | 1 | Receive interrupt request (level) |
| tx_irq | output | 1 | Transmit interrupt request (level) |

## Verification
Wrong internal state shows at the ports at different speeds. A wrong ready or enable flag shows at once: in the interrupt lines in the next cycle, and in the control word on the next load. A wrong held receive character stays hidden until receive data is loaded. A fault in the transmit countdown shows only when the send completes, `TX_DELAY` cycles after the store, as a pulse that comes early, comes late or is missing. The bench therefore compares every output against a behavioural model on every cycle, and it times the send edge by edge.

// File: rtl/mmio_term_pkg.sv
package mmio_term_pkg;
   typedef enum logic [1:0] {
      SLOT_RX_CTL = 2'd0,
      SLOT_RX_DAT = 2'd1,
      SLOT_TX_CTL = 2'd2,
      SLOT_TX_DAT = 2'd3
   } slot_e;

   localparam int RDY_POS = 0;
   localparam int IEN_POS = 1;

   typedef struct packed {
      logic  rd;
      logic  wr;
      slot_e slot;
   } acc_t;
endpackage

// File: rtl/mmio_term_decode.sv
module mmio_term_decode
   import mmio_term_pkg::*;
#(
   parameter int          ADDR_W = 32,
   parameter logic [31:0] BASE   = 32'hFFFF_0000
) (
   input  logic              sel,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   output acc_t              acc
);
   localparam logic [ADDR_W-1:0] BASE_A = BASE[ADDR_W-1:0];

   initial begin
      if (ADDR_W < 5 || ADDR_W > 32) $error("ADDR_W must lie in 5..32");
      if (BASE[3:0] != 4'h0) $error("BASE must be aligned to 16 bytes");
   end

   logic hit;
   assign hit = (addr[ADDR_W-1:4] == BASE_A[ADDR_W-1:4]);

   always_comb begin
      acc.rd   = sel && !we && hit;
      acc.wr   = sel &&  we && hit;
      acc.slot = slot_e'(addr[3:2]);
   end
endmodule

// File: rtl/mmio_term_rx.sv
module mmio_term_rx #(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [CHAR_W-1:0] in_char,
   input  logic              take,
   input  logic              ctl_wr,
   input  logic              ctl_en,
   output logic              ready,
   output logic              en,
   output logic [CHAR_W-1:0] held
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready <= 1'b0;
         held  <= '0;
      end else if (in_valid) begin
         ready <= 1'b1;
         held  <= in_char;
      end else if (take) begin
         ready <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en <= 1'b0;
      else if (ctl_wr) en <= ctl_en;
   end
endmodule

// File: rtl/mmio_term_tx.sv
module mmio_term_tx #(
   parameter int CHAR_W   = 8,
   parameter int TX_DELAY = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dat_wr,
   input  logic [CHAR_W-1:0] dat_char,
   input  logic              ctl_wr,
   input  logic              ctl_en,
   output logic              ready,
   output logic              en,
   output logic              out_valid,
   output logic [CHAR_W-1:0] out_char
);
   initial begin
      if (TX_DELAY < 1) $error("TX_DELAY must be at least 1");
   end

   logic              start;
   logic              finish;
   logic [CHAR_W-1:0] pend;

   assign start = dat_wr && ready;

   generate
      if (TX_DELAY == 1) begin : g_one
         assign finish = !ready;
      end else begin : g_cnt
         localparam int CNT_W = $clog2(TX_DELAY + 1);
         localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TX_DELAY);
         localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     cnt <= '0;
            else if (start) cnt <= CNT_LOAD;
            else if (!ready && cnt != '0) cnt <= cnt - 1'b1;
         end
         assign finish = !ready && (cnt == CNT_LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready     <= 1'b1;
         pend      <= '0;
         out_valid <= 1'b0;
         out_char  <= '0;
      end else begin
         out_valid <= 1'b0;
         if (finish) begin
            ready     <= 1'b1;
            out_valid <= 1'b1;
            out_char  <= pend;
         end else if (start) begin
            ready <= 1'b0;
            pend  <= dat_char;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en <= 1'b0;
      else if (ctl_wr) en <= ctl_en;
   end
endmodule

// File: rtl/mmio_term.sv
module mmio_term
   import mmio_term_pkg::*;
#(
   parameter int          ADDR_W   = 32,
   parameter int          DATA_W   = 32,
   parameter int          CHAR_W   = 8,
   parameter int          TX_DELAY = 20,
   parameter logic [31:0] BASE     = 32'hFFFF_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              rx_in_valid,
   input  logic [CHAR_W-1:0] rx_in_char,
   output logic              tx_out_valid,
   output logic [CHAR_W-1:0] tx_out_char,
   output logic              rx_irq,
   output logic              tx_irq
);
   initial begin
      if (DATA_W < 2) $error("DATA_W must hold both control bits");
      if (CHAR_W < 1 || CHAR_W > DATA_W) $error("CHAR_W must lie in 1..DATA_W");
   end

   acc_t              acc;
   logic              rx_rdy, rx_en, tx_rdy, tx_en;
   logic [CHAR_W-1:0] rx_held;
   logic              unused_wdata;

   assign unused_wdata = ^bus_wdata;

   mmio_term_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
      .sel  (bus_sel),
      .we   (bus_we),
      .addr (bus_addr),
      .acc  (acc)
   );

   mmio_term_rx #(.CHAR_W(CHAR_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (rx_in_valid),
      .in_char  (rx_in_char),
      .take     (acc.rd && acc.slot == SLOT_RX_DAT),
      .ctl_wr   (acc.wr && acc.slot == SLOT_RX_CTL),
      .ctl_en   (bus_wdata[IEN_POS]),
      .ready    (rx_rdy),
      .en       (rx_en),
      .held     (rx_held)
   );

   mmio_term_tx #(.CHAR_W(CHAR_W), .TX_DELAY(TX_DELAY)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .dat_wr    (acc.wr && acc.slot == SLOT_TX_DAT),
      .dat_char  (bus_wdata[CHAR_W-1:0]),
      .ctl_wr    (acc.wr && acc.slot == SLOT_TX_CTL),
      .ctl_en    (bus_wdata[IEN_POS]),
      .ready     (tx_rdy),
      .en        (tx_en),
      .out_valid (tx_out_valid),
      .out_char  (tx_out_char)
   );

   always_comb begin
      bus_rdata = '0;
      if (acc.rd) begin
         unique case (acc.slot)
            SLOT_RX_CTL: begin
               bus_rdata[RDY_POS] = rx_rdy;
               bus_rdata[IEN_POS] = rx_en;
            end
            SLOT_RX_DAT: bus_rdata[CHAR_W-1:0] = rx_held;
            SLOT_TX_CTL: begin
               bus_rdata[RDY_POS] = tx_rdy;
               bus_rdata[IEN_POS] = tx_en;
            end
            default: bus_rdata = '0;
         endcase
      end
   end

   assign rx_irq = rx_en && rx_rdy;
   assign tx_irq = tx_en && tx_rdy;
endmodule

// File: rtl/mmio_term_chk.sv
module mmio_term_chk #(
   parameter int          ADDR_W = 32,
   parameter int          DATA_W = 32,
   parameter logic [31:0] BASE   = 32'hFFFF_0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              rx_in_valid,
   input logic              tx_out_valid,
   input logic              rx_irq,
   input logic              tx_irq,
   input logic              rx_rdy,
   input logic              tx_rdy
);
   localparam logic [ADDR_W-1:0] BASE_A = BASE[ADDR_W-1:0];

   logic in_win, rd_rxd, wr_rxc, wr_txc, wr_txd;
   assign in_win = bus_sel && (bus_addr[ADDR_W-1:4] == BASE_A[ADDR_W-1:4]);
   assign rd_rxd = in_win && !bus_we && bus_addr[3:2] == 2'd1;
   assign wr_rxc = in_win &&  bus_we && bus_addr[3:2] == 2'd0;
   assign wr_txc = in_win &&  bus_we && bus_addr[3:2] == 2'd2;
   assign wr_txd = in_win &&  bus_we && bus_addr[3:2] == 2'd3;

   AST_RX_ARRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_in_valid |=> rx_rdy); // R4
   AST_RX_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rxd && !rx_in_valid) |=> !rx_rdy); // R5
   AST_CTL_KEEPS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_rxc && !rx_in_valid) |=> (rx_rdy == $past(rx_rdy))); // R3
   AST_TX_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_txd && tx_rdy) |=> !tx_rdy); // R7
   AST_TX_DONE_RDY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_out_valid |-> tx_rdy); // R7
   AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_out_valid |=> !tx_out_valid); // R7
   AST_IRQ_ON_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_rxc && bus_wdata[1] && rx_rdy) |=> rx_irq); // R9
   AST_IRQ_OFF_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_txc && !bus_wdata[1]) |=> !tx_irq); // R9
endmodule

bind mmio_term mmio_term_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(BASE)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_sel      (bus_sel),
   .bus_we       (bus_we),
   .bus_addr     (bus_addr),
   .bus_wdata    (bus_wdata),
   .rx_in_valid  (rx_in_valid),
   .tx_out_valid (tx_out_valid),
   .rx_irq       (rx_irq),
   .tx_irq       (tx_irq),
   .rx_rdy       (rx_rdy),
   .tx_rdy       (tx_rdy)
);

// File: tb/mmio_term_test.sv
module mmio_term_test;
   localparam int          PERIOD = 10;
   localparam int          DLY    = 20;
   localparam logic [31:0] BASE   = 32'hFFFF_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [31:0] bus_addr = '0, bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rx_in_valid = 1'b0;
   logic [7:0]  rx_in_char = '0;
   logic        tx_out_valid;
   logic [7:0]  tx_out_char;
   logic        rx_irq, tx_irq;

   int checks = 0, fails = 0;
   bit done = 0;

   // behavioural model state
   bit       m_rxr = 0, m_rxe = 0, m_txr = 1, m_txe = 0, m_ov = 0;
   int       m_cnt = 0;
   bit [7:0] m_rxc = 0, m_txc = 0, m_oc = 0;

   always #(PERIOD/2) clk = ~clk;

   mmio_term #(.TX_DELAY(DLY), .BASE(BASE)) uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_in_valid(rx_in_valid), .rx_in_char(rx_in_char),
      .tx_out_valid(tx_out_valid), .tx_out_char(tx_out_char),
      .rx_irq(rx_irq), .tx_irq(tx_irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] m_rdata(input bit s, input bit w, input logic [31:0] a);
      logic [31:0] r = '0;
      if (s && !w && a[31:4] == BASE[31:4]) begin
         case (a[3:2])
            2'd0: r = {30'd0, m_rxe, m_rxr};
            2'd1: r = {24'd0, m_rxc};
            2'd2: r = {30'd0, m_txe, m_txr};
            default: r = '0;
         endcase
      end
      return r;
   endfunction

   task automatic m_edge(input bit s, input bit w, input logic [31:0] a, input logic [31:0] d,
                         input bit v, input logic [7:0] c);
      bit hit = s && a[31:4] == BASE[31:4];
      bit [1:0] ix = a[3:2];
      if (v) begin m_rxr = 1; m_rxc = c; end
      else if (hit && !w && ix == 1) m_rxr = 0;
      if (hit && w && ix == 0) m_rxe = d[1];
      if (hit && w && ix == 2) m_txe = d[1];
      m_ov = 0;
      if (!m_txr) begin
         if (m_cnt == 1) begin m_txr = 1; m_ov = 1; m_oc = m_txc; end
         m_cnt--;
      end else if (hit && w && ix == 3) begin
         m_txr = 0; m_txc = d[7:0]; m_cnt = DLY;
      end
   endtask

   task automatic step(input bit s, input bit w, input logic [31:0] a, input logic [31:0] d,
                       input bit v, input logic [7:0] c, output logic [31:0] rd);
      bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d;
      rx_in_valid = v; rx_in_char = c;
      #1;
      chk("MODEL rdata", bus_rdata, m_rdata(s, w, a));
      chk("MODEL rx_irq", {31'd0, rx_irq}, {31'd0, m_rxe & m_rxr});
      chk("MODEL tx_irq", {31'd0, tx_irq}, {31'd0, m_txe & m_txr});
      chk("MODEL tx_out_valid", {31'd0, tx_out_valid}, {31'd0, m_ov});
      if (m_ov) chk("MODEL tx_out_char", {24'd0, tx_out_char}, {24'd0, m_oc});
      rd = bus_rdata;
      @(posedge clk);
      m_edge(s, w, a, d, v, c);
      @(negedge clk);
   endtask

   task automatic idle();
      logic [31:0] x;
      step(0, 0, 0, 0, 0, 0, x);
   endtask
   task automatic rd(input logic [31:0] off, output logic [31:0] r);
      step(1, 0, BASE + off, 0, 0, 0, r);
   endtask
   task automatic wr(input logic [31:0] off, input logic [31:0] d);
      logic [31:0] x;
      step(1, 1, BASE + off, d, 0, 0, x);
   endtask
   task automatic rx(input logic [7:0] c);
      logic [31:0] x;
      step(0, 0, 0, 0, 1, c, x);
   endtask

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      int k;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10 reset state
      rd(0, r);  chk("R10 rx ctl", r, 32'h0);
      rd(8, r);  chk("R10 tx ctl", r, 32'h1);
      chk("R10 irqs", {30'd0, rx_irq, tx_irq}, 32'h0);
      chk("R10 tx_out_valid", {31'd0, tx_out_valid}, 32'h0);

      // R4 arrival and load
      rx(8'h41);
      rd(0, r);  chk("R4 rx ready", r, 32'h1);
      rd(4, r);  chk("R4 rx data", r, 32'h41);
      rd(0, r);  chk("R5 ready cleared by load", r, 32'h0);

      // R6 overwrite
      rx(8'h42); rx(8'h43);
      rd(4, r);  chk("R6 overwrite", r, 32'h43);

      // R5 arrival at the same edge as the load
      step(1, 0, BASE + 4, 0, 1, 8'h44, r);
      chk("R5 load returns old char", r, 32'h43);
      rd(0, r);  chk("R5 arrival wins", r, 32'h1);

      // R2/R3/R9 control writes
      wr(0, 32'hFFFF_FFFE);
      chk("R9 rx_irq after enable", {31'd0, rx_irq}, 32'h1);
      rd(0, r);  chk("R2 ctl layout", r, 32'h3);
      wr(0, 32'h0000_0001);
      rd(0, r);  chk("R3 ready kept", r, 32'h1);
      chk("R9 rx_irq off", {31'd0, rx_irq}, 32'h0);

      // R11 data side no-ops
      wr(4, 32'h55);
      rd(0, r);  chk("R11 rx data store keeps ready", r, 32'h1);
      rd(12, r); chk("R11 tx data load", r, 32'h0);
      rd(8, r);  chk("R11 tx ready untouched", r, 32'h1);
      rd(4, r);  chk("R11 rx data store ignored", r, 32'h44);

      // R1 outside the window and bits 1:0 ignored
      step(1, 1, BASE + 32'h10, 32'h2, 0, 0, r);
      rd(8, r);  chk("R1 outside store ignored", r, 32'h1);
      step(1, 0, BASE + 32'h10, 0, 0, 0, r);
      chk("R1 outside load", r, 32'h0);
      step(1, 0, BASE - 32'h8, 0, 0, 0, r);
      chk("R1 below base", r, 32'h0);
      rx(8'h5A);
      step(1, 0, BASE + 32'h6, 0, 0, 0, r);
      chk("R1 low bits ignored", r, 32'h5A);

      // R7/R8/R9 transmit
      wr(8, 32'h2);
      chk("R9 tx_irq after enable", {31'd0, tx_irq}, 32'h1);
      wr(12, 32'h1A5);
      chk("R7 tx_irq drops", {31'd0, tx_irq}, 32'h0);
      k = 0;
      while (!tx_out_valid && k < 100) begin
         k++;
         if (k == 1) wr(12, 32'h77);
         else idle();
      end
      chk("R7 delay", k, DLY);
      chk("R8 char kept", {24'd0, tx_out_char}, 32'hA5);
      rd(8, r);  chk("R7 ready back", r, 32'h3);
      k = 0;
      for (int i = 0; i < DLY + 2; i++) begin
         idle();
         if (tx_out_valid) k++;
      end
      chk("R8 no second send", k, 0);

      // random phase against the model
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] off;
         case ($urandom_range(0, 5))
            0: off = 0; 1: off = 4; 2: off = 8; 3: off = 12;
            4: off = 32'h10; default: off = 32'h1;
         endcase
         step($urandom_range(0, 1), $urandom_range(0, 1), BASE + off, $urandom,
              ($urandom_range(0, 7) == 0), 8'($urandom), r);
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule